// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps calendar time in packed BCD: century, year, month, day of month, day of week, hours (24-hour form), minutes and seconds. A set of internal counters advances on each one-cycle pulse of a 1 Hz tick. The calendar handles 28-, 29-, 30- and 31-day months, and any year divisible by four is a leap year. When the year rolls over from 99 to 00, the century increments.

Software never reads the counters directly. It reads a second bank of registers that is refreshed from the counters once per second, with every field updated in the same cycle. A control byte holds two freeze bits. The snapshot bit freezes the visible bank so that a multi-byte read is consistent. The set bit also freezes the bank, and it opens the time fields for writing. Clearing the set bit copies the visible bank into the counters. A stop flag in the top bit of the seconds byte halts time advance. That flag can be written at any time.

The register port is byte-wide and uses a 4-bit offset. Writes take effect on the clock edge. Read data appears on the edge that samples the read strobe.

Top module: `rtc_calendar`

## Requirements
- R1: Each enabled tick advances the counters by one second. Seconds and minutes wrap from 59 to 00 and carry. Hours wrap from 23 to 00 and carry into both the day of month and the day of week. The day of week runs from 1 to 7 and then wraps to 1.
- R2: The last day of a month is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11. For month 02 it is 29 when the BCD year is divisible by 4 and 28 otherwise. After the last day the date becomes 01 and the month advances.
- R3: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and increments the century in BCD.
- R4: The visible bank is reloaded from the counters on the clock edge one cycle after the tick, with all fields at once. A read strobe sampled on an edge returns, on that edge, the value held before the edge.
- R5: Writing 1 to control bit 6 (snapshot) stops the refreshes while the counters keep running. Once the bit is written back to 0, the next tick refreshes the bank with the current count.
- R6: A control write that sets a freeze bit on the same edge as a refresh does not cancel that refresh.
- R7: Writing 1 to control bit 7 (set) stops the refreshes and makes the time fields writable. While the bit is 0, writes to the time fields are ignored. Writing 0 to the bit while it is 1 copies the visible bank into the counters. A tick on that same edge is dropped, so the next advance comes with the next tick.
- R8: Bit 7 of the seconds byte is the stop flag. It can be written whether or not the set bit is 1. While the flag is 1 the counters do not advance, and the flag reads back in bit 7 of the seconds byte.
- R9: After reset both freeze bits and the stop flag are 0, and the time is century 20, year 00, month 01, date 01, day 1, 00:00:00.
- R10: The offsets are: 0xF year, 0xE month, 0xD date, 0xC day of week, 0xB hours, 0xA minutes, 0x9 seconds, 0x8 control, 0x1 century. Every other offset reads as 0, as do control bits 5..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Read data, registered on a read strobe |

## Verification
Two functions can fall on the same edge. In the first, a refresh coincides with a control write that sets the snapshot bit: the bench drives the control write in the cycle right after a tick. It then judges the result by reading seconds, which must already show the new count, and by checking that a later tick does not change it. In the second, clearing the set bit coincides with a tick. The load must win, so the seconds read back exactly as written, and only the following tick adds one.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 4;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [OFS_W-1:0]  ofs_t;

    localparam ofs_t OFS_YEAR  = 4'hF;
    localparam ofs_t OFS_MONTH = 4'hE;
    localparam ofs_t OFS_DATE  = 4'hD;
    localparam ofs_t OFS_WDAY  = 4'hC;
    localparam ofs_t OFS_HOUR  = 4'hB;
    localparam ofs_t OFS_MIN   = 4'hA;
    localparam ofs_t OFS_SEC   = 4'h9;
    localparam ofs_t OFS_CTRL  = 4'h8;
    localparam ofs_t OFS_CENT  = 4'h1;

    localparam int CTRL_SET_BIT  = 7;
    localparam int CTRL_SNAP_BIT = 6;
    localparam int SEC_STOP_BIT  = 7;

    typedef struct packed {
        byte_t cent;
        byte_t year;
        byte_t month;
        byte_t date;
        byte_t wday;
        byte_t hour;
        byte_t minute;
        byte_t second;
    } cal_t;

    localparam cal_t CAL_RESET = '{cent: 8'h20, year: 8'h00, month: 8'h01,
                                   date: 8'h01, wday: 8'h01, hour: 8'h00,
                                   minute: 8'h00, second: 8'h00};

    // BCD +1 on a two-digit byte
    function automatic byte_t bcd_inc(byte_t v);
        if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
        return v + 8'h01;
    endfunction

    function automatic logic roll_wrap(byte_t v, byte_t last);
        return v == last;
    endfunction

    function automatic byte_t roll_val(byte_t v, byte_t last, byte_t first);
        return (v == last) ? first : bcd_inc(v);
    endfunction

    // 10*t + o is divisible by 4 exactly when 2*t + o is
    function automatic logic leap_year(byte_t yr);
        if (yr[4]) return (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
        return (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
    endfunction

    function automatic byte_t month_last_day(byte_t mon, byte_t yr);
        case (mon)
            8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // writable bits per time field
    function automatic byte_t field_mask(ofs_t ofs);
        case (ofs)
            OFS_SEC, OFS_MIN: return 8'h7F;
            OFS_HOUR, OFS_DATE: return 8'h3F;
            OFS_MONTH:        return 8'h1F;
            OFS_WDAY:         return 8'h07;
            default:          return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
    import rtc_cal_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);
    logic c_sec, c_min, c_hour, c_date, c_mon, c_year;

    always_comb begin
        nxt    = cur;
        c_sec  = roll_wrap(cur.second, 8'h59);
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_date = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        nxt.second = roll_val(cur.second, 8'h59, 8'h00);
        if (c_sec) begin
            c_min      = roll_wrap(cur.minute, 8'h59);
            nxt.minute = roll_val(cur.minute, 8'h59, 8'h00);
        end
        if (c_min) begin
            c_hour   = roll_wrap(cur.hour, 8'h23);
            nxt.hour = roll_val(cur.hour, 8'h23, 8'h00);
        end
        if (c_hour) begin
            nxt.wday = roll_val(cur.wday, 8'h07, 8'h01);
            c_date   = roll_wrap(cur.date, month_last_day(cur.month, cur.year));
            nxt.date = roll_val(cur.date, month_last_day(cur.month, cur.year), 8'h01);
        end
        if (c_date) begin
            c_mon     = roll_wrap(cur.month, 8'h12);
            nxt.month = roll_val(cur.month, 8'h12, 8'h01);
        end
        if (c_mon) begin
            c_year   = roll_wrap(cur.year, 8'h99);
            nxt.year = roll_val(cur.year, 8'h99, 8'h00);
        end
        if (c_year) begin
            nxt.cent = roll_val(cur.cent, 8'h99, 8'h00);
        end
    end

endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic load,
    input  cal_t load_val,
    input  logic stop_we,
    input  logic stop_val,
    output cal_t cnt,
    output logic stopped
);
    cal_t cnt_next;

    rtc_cal_step u_step (
        .cur (cnt),
        .nxt (cnt_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= CAL_RESET;
            stopped <= 1'b0;
        end else begin
            if (stop_we) stopped <= stop_val;
            if (load) begin
                cnt <= load_val;
            end else if (tick && !stopped) begin
                cnt <= cnt_next;
            end
        end
    end

    // R1: an enabled tick always moves the count
    assert_tick_advances_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && !stopped && !load) |=> (cnt != $past(cnt)));

    // R8: a set stop flag holds the count
    assert_stop_freezes_R8: assert property (@(posedge clk) disable iff (rst)
        (stopped && !load) |=> $stable(cnt));

    // R7: a load takes the visible bank as it stood
    assert_load_copies_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/rtc_cal_visible.sv
module rtc_cal_visible
    import rtc_cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  wr_en,
    input  ofs_t  addr,
    input  byte_t wdata,
    input  cal_t  cnt,
    output cal_t  vis,
    output logic  snap_bit,
    output logic  set_bit,
    output logic  load,
    output logic  stop_we,
    output logic  stop_val
);
    logic  refresh_q;
    logic  ctrl_wr;
    byte_t wmasked;

    assign ctrl_wr  = wr_en && (addr == OFS_CTRL);
    assign load     = ctrl_wr && set_bit && !wdata[CTRL_SET_BIT];
    assign stop_we  = wr_en && (addr == OFS_SEC);
    assign stop_val = wdata[SEC_STOP_BIT];
    assign wmasked  = wdata & field_mask(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            vis       <= CAL_RESET;
            snap_bit  <= 1'b0;
            set_bit   <= 1'b0;
            refresh_q <= 1'b0;
        end else begin
            refresh_q <= tick;
            // freeze bits sampled before this edge's write: a halt never aborts a refresh
            if (refresh_q && !snap_bit && !set_bit) vis <= cnt;
            if (ctrl_wr) begin
                set_bit  <= wdata[CTRL_SET_BIT];
                snap_bit <= wdata[CTRL_SNAP_BIT];
            end else if (wr_en && set_bit) begin
                case (addr)
                    OFS_YEAR:  vis.year   <= wmasked;
                    OFS_MONTH: vis.month  <= wmasked;
                    OFS_DATE:  vis.date   <= wmasked;
                    OFS_WDAY:  vis.wday   <= wmasked;
                    OFS_HOUR:  vis.hour   <= wmasked;
                    OFS_MIN:   vis.minute <= wmasked;
                    OFS_SEC:   vis.second <= wmasked;
                    OFS_CENT:  vis.cent   <= wmasked;
                    default:   ;
                endcase
            end
        end
    end

    // R4: an unfrozen refresh takes the whole count
    assert_refresh_copies_R4: assert property (@(posedge clk) disable iff (rst)
        (refresh_q && !snap_bit && !set_bit && !wr_en) |=> (vis == $past(cnt)));

    // R6: a halt written on the refresh edge does not cancel it
    assert_halt_keeps_refresh_R6: assert property (@(posedge clk) disable iff (rst)
        (refresh_q && !snap_bit && !set_bit && ctrl_wr) |=> (vis == $past(cnt)));

    // R5: a frozen bank changes only by a write
    assert_frozen_bank_R5: assert property (@(posedge clk) disable iff (rst)
        ((snap_bit || set_bit) && !wr_en) |=> $stable(vis));

    // R9: freeze bits come out of reset cleared
    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!snap_bit && !set_bit));

endmodule

// File: rtl/rtc_cal_readport.sv
module rtc_cal_readport
    import rtc_cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_en,
    input  ofs_t  addr,
    input  cal_t  vis,
    input  logic  stopped,
    input  logic  snap_bit,
    input  logic  set_bit,
    output byte_t rd_data
);
    byte_t sel;

    always_comb begin
        case (addr)
            OFS_YEAR:  sel = vis.year;
            OFS_MONTH: sel = vis.month;
            OFS_DATE:  sel = vis.date;
            OFS_WDAY:  sel = vis.wday;
            OFS_HOUR:  sel = vis.hour;
            OFS_MIN:   sel = vis.minute;
            OFS_SEC:   sel = vis.second | (byte_t'(stopped) << SEC_STOP_BIT);
            OFS_CTRL:  sel = (byte_t'(set_bit) << CTRL_SET_BIT) |
                             (byte_t'(snap_bit) << CTRL_SNAP_BIT);
            OFS_CENT:  sel = vis.cent;
            default:   sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= sel;
    end

    // R10: read data only moves on a read strobe
    assert_read_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = rtc_cal_pkg::OFS_W,
    parameter int DATA_W = rtc_cal_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    cal_t cnt, vis;
    logic stopped, snap_bit, set_bit, load, stop_we, stop_val;

    rtc_cal_visible u_visible (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1hz),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .cnt      (cnt),
        .vis      (vis),
        .snap_bit (snap_bit),
        .set_bit  (set_bit),
        .load     (load),
        .stop_we  (stop_we),
        .stop_val (stop_val)
    );

    rtc_cal_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1hz),
        .load     (load),
        .load_val (vis),
        .stop_we  (stop_we),
        .stop_val (stop_val),
        .cnt      (cnt),
        .stopped  (stopped)
    );

    rtc_cal_readport u_read (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .addr     (addr),
        .vis      (vis),
        .stopped  (stopped),
        .snap_bit (snap_bit),
        .set_bit  (set_bit),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/test_rtc_calendar.sv
`timescale 1ns/1ps
module test_rtc_calendar;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic [3:0] addr = 4'h0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rtc_calendar i_rtc_calendar (
        .clk      (clk),
        .rst      (rst),
        .tick_1hz (tick_1hz),
        .addr     (addr),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .rd_en    (rd_en),
        .rd_data  (rd_data)
    );

    typedef struct {
        logic [3:0] a;
        logic [7:0] e;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    logic mon_go = 1'b0;

    // monitor: one result per sampled read strobe
    always @(posedge clk) mon_go <= rd_en;

    always @(negedge clk) begin
        if (mon_go) begin
            exp_t it;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read data %02h with no expected item", rd_data);
            end else begin
                it = exp_q.pop_front();
                if (rd_data !== it.e) begin
                    errors++;
                    $display("FAIL %s: offset %h actual %02h expected %02h",
                             it.tag, it.a, rd_data, it.e);
                end
            end
        end
    end

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        it.a = a; it.e = e; it.tag = tag;
        exp_q.push_back(it);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick1();
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] cen, yr, mon, dt, wd, hr, mi, se);
        wr(4'h8, 8'h80);
        wr(4'h1, cen); wr(4'hF, yr); wr(4'hE, mon); wr(4'hD, dt);
        wr(4'hC, wd);  wr(4'hB, hr); wr(4'hA, mi);  wr(4'h9, se);
        wr(4'h8, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state and map
        rd(4'hF, 8'h00, "R9 year");
        rd(4'hE, 8'h01, "R9 month");
        rd(4'hD, 8'h01, "R9 date");
        rd(4'hC, 8'h01, "R9 wday");
        rd(4'hB, 8'h00, "R9 hour");
        rd(4'hA, 8'h00, "R9 minute");
        rd(4'h9, 8'h00, "R9 second/stop");
        rd(4'h8, 8'h00, "R9 control");
        rd(4'h1, 8'h20, "R9 century");
        rd(4'h3, 8'h00, "R10 unused offset");

        // refresh timing: read on the refresh edge sees the old value
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        rd(4'h9, 8'h00, "R4 read on refresh edge");
        rd(4'h9, 8'h01, "R4 read after refresh");

        // time write ignored while set bit clear
        wr(4'hA, 8'h45);
        rd(4'hA, 8'h00, "R7 write ignored");

        // full rollover
        set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
        rd(4'h9, 8'h59, "R7 loaded second");
        tick1();
        rd(4'h9, 8'h00, "R1 second wrap");
        rd(4'hA, 8'h00, "R1 minute wrap");
        rd(4'hB, 8'h00, "R1 hour wrap");
        rd(4'hC, 8'h01, "R1 wday wrap");
        rd(4'hD, 8'h01, "R2 date wrap dec");
        rd(4'hE, 8'h01, "R3 month wrap");
        rd(4'hF, 8'h00, "R3 year wrap");
        rd(4'h1, 8'h21, "R3 century carry");

        // set bit freezes; clear collides with a tick
        wr(4'h8, 8'h80);
        tick1();
        rd(4'h9, 8'h00, "R7 frozen under set");
        wr(4'h9, 8'h30);
        addr = 4'h8; wdata = 8'h00; wr_en = 1'b1; tick_1hz = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1hz = 1'b0;
        @(negedge clk);
        rd(4'h9, 8'h30, "R7 tick dropped on load");
        rd(4'hA, 8'h00, "R7 minute loaded");
        tick1();
        rd(4'h9, 8'h31, "R7 next tick advances");

        // month lengths
        set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        tick1();
        rd(4'hD, 8'h01, "R2 feb non-leap date");
        rd(4'hE, 8'h03, "R2 feb non-leap month");
        set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        tick1();
        rd(4'hD, 8'h29, "R2 feb leap 29th");
        rd(4'hE, 8'h02, "R2 feb leap month");
        set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h03, 8'h23, 8'h59, 8'h59);
        tick1();
        rd(4'hD, 8'h01, "R2 leap feb end");
        rd(4'hE, 8'h03, "R2 leap march");
        set_time(8'h20, 8'h24, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        tick1();
        rd(4'hD, 8'h01, "R2 30-day end");
        rd(4'hE, 8'h05, "R2 30-day month");
        set_time(8'h20, 8'h24, 8'h01, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
        tick1();
        rd(4'hD, 8'h01, "R2 31-day end");
        rd(4'hE, 8'h02, "R2 31-day month");
        rd(4'hB, 8'h00, "R1 hour after day");

        // snapshot freeze
        wr(4'h8, 8'h40);
        tick1(); tick1(); tick1();
        rd(4'h9, 8'h00, "R5 frozen second");
        rd(4'h8, 8'h40, "R5 snapshot readback");
        wr(4'h8, 8'h00);
        rd(4'h9, 8'h00, "R5 no refresh before tick");
        tick1();
        rd(4'h9, 8'h04, "R5 counters kept running");

        // halt written on the refresh edge
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        wr(4'h8, 8'h40);
        rd(4'h9, 8'h05, "R6 refresh completed");
        tick1();
        rd(4'h9, 8'h05, "R6 then frozen");
        wr(4'h8, 8'h00);
        tick1();
        rd(4'h9, 8'h07, "R6 resumed");

        // stop flag without set bit
        wr(4'h9, 8'h80);
        rd(4'h9, 8'h87, "R8 stop readback");
        tick1(); tick1();
        rd(4'h9, 8'h87, "R8 stopped");
        wr(4'h9, 8'h00);
        rd(4'h9, 8'h07, "R8 stop cleared");
        tick1();
        rd(4'h9, 8'h08, "R8 restarted");
        rd(4'hA, 8'h00, "R8 minute untouched");

        rd(4'h0, 8'h00, "R10 offset 0");
        rd(4'h7, 8'h00, "R10 offset 7");

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule